// File: doc/BRIEF.md
# Gated Pulse Counter and Timer

This block counts rising edges on several count inputs. Each channel counts only inside a gate interval. An interval is defined in one of two ways. In level mode the interval lasts while the channel's gate is high. In edge mode it runs from one rising edge of the gate to the next.

The gate of a channel comes either from its own gate pin or from a shared window generator. The generator counts down from a programmable reload value, so that window has an exact length in system clock cycles. With the shared window, several channels measure frequency over the same interval. With a known clock on the count input and the measured signal on the gate, a channel measures pulse width or the time between two events.

All pins are synchronized into the system clock domain before use. When an interval ends, its count is copied into a readout register and a done flag is raised. A count that runs past the counter range stops at the maximum value and sets a sticky overflow flag.

Top module: `gpc_counter`

## Requirements
- R1: Count and gate pins pass through a two-stage synchronizer. Each low-to-high transition of a synchronized count input adds exactly one to that channel's count while the interval is open.
- R2: With mode bit `cfg_data[0]` = 0 (level mode), a channel counts only while its gate is high. Count pulses while the gate is low have no effect on the next readout.
- R3: With mode bit `cfg_data[0]` = 1 (edge mode), a rising edge of the gate opens the interval and the following rising edge closes it. The count equals the count-input rises between those two edges.
- R4: When an interval closes, the count is copied into `rd_count` and `done` is set. `rd_count` holds its value until the next close. `done` clears when the next interval opens. After reset `rd_count`, `done` and `ovf` are zero.
- R5: The count saturates at 65535 (16 bits) and does not wrap. Reaching saturation on a further rise sets the channel's `ovf`, which stays set through the readout and clears when the next interval opens.
- R6: A write with `cfg_sel` = NCH loads the 16-bit reload value. A `gen_start` pulse while the generator is idle drives `gen_gate_out` high for exactly reload cycles. A `gen_start` while the window is running is ignored. A `gen_start` with reload 0 is ignored.
- R7: With gate-select bit `cfg_data[1]` = 1 (written with `cfg_sel` = channel index), a channel uses the shared generated window instead of its gate pin. Several channels can share one window.
- R8: `chan_out` of a channel is high while its interval is open: the synchronized gate in level mode, and between the opening and closing edges in edge mode.
- R9: With a free-running clock of period P cycles on a count input and a gate high for W cycles (W a multiple of P), the readout equals W/P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cnt_pin | input | NCH | Count input per channel (asynchronous) |
| gate_pin | input | NCH | Gate input per channel (asynchronous) |
| gen_start | input | 1 | Starts one window of the shared gate generator |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | clog2(NCH+1) | Channel index, or NCH for the reload value |
| cfg_data | input | CW | Bit 0 mode, bit 1 gate select; full word for reload |
| chan_out | output | NCH | Interval-open indication per channel |
| gen_gate_out | output | 1 | Shared generated gate window |
| rd_count | output | NCH*CW | Latched final counts, channel 0 in the low bits |
| done | output | NCH | Interval-closed flag per channel |
| ovf | output | NCH | Sticky saturation flag per channel |

## Verification
In the level-mode test, pulses are sent both before the gate rises and inside the window. A design that counts outside the gate gives a different result. The edge-mode test keeps the gate pin low between its two opening and closing pulses, which separates edge behaviour from level behaviour. A steady toggling input inside a fixed-length pin gate and a generated window checks the width-over-period relation, the exact window length and the sharing of one window by two channels. A run longer than the counter range checks saturation and overflow, and the interval that follows checks that the flag clears.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic {
    GM_LEVEL = 1'b0,
    GM_EDGE  = 1'b1
  } gate_mode_e;

  typedef struct packed {
    logic       gen_sel;
    gate_mode_e mode;
  } chan_cfg_t;

endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpc_gate_gen.sv
module gpc_gate_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] reload,
  output logic          gate_q
);
  logic [CW-1:0] left_q;

  function automatic logic [CW-1:0] tick_down(input logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      left_q <= '0;
    end else if (!gate_q) begin
      if (start && reload != '0) begin
        gate_q <= 1'b1;
        left_q <= reload;
      end
    end else if (left_q == CW'(1)) begin
      gate_q <= 1'b0;
    end else begin
      left_q <= tick_down(left_q);
    end
  end
endmodule

// File: rtl/gpc_chan.sv
module gpc_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_lvl,
  input  logic          gate_lvl,
  input  logic          mode_edge,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] rd_q,
  output logic          done_q,
  output logic          ovf_q,
  output logic          open_o,
  output logic          start_o,
  output logic          end_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic cnt_prev, gate_prev, armed_q;
  logic cnt_rise, g_rise, g_fall, counting;

  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] v);
    return (v == CMAX) ? v : v + CW'(1);
  endfunction

  assign cnt_rise = cnt_lvl & ~cnt_prev;
  assign g_rise   = gate_lvl & ~gate_prev;
  assign g_fall   = ~gate_lvl & gate_prev;
  assign start_o  = mode_edge ? (g_rise & ~armed_q) : g_rise;
  assign end_o    = mode_edge ? (g_rise & armed_q) : g_fall;
  assign counting = mode_edge ? armed_q : gate_lvl;
  assign open_o   = mode_edge ? armed_q : gate_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_prev  <= 1'b0;
      gate_prev <= 1'b0;
    end else begin
      cnt_prev  <= cnt_lvl;
      gate_prev <= gate_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (start_o) begin
      cnt_q   <= cnt_rise ? CW'(1) : '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= mode_edge;
    end else if (end_o) begin
      rd_q    <= cnt_q;
      done_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (counting && cnt_rise) begin
      if (cnt_q == CMAX) ovf_q <= 1'b1;
      cnt_q <= sat_step(cnt_q);
    end
  end
endmodule

// File: rtl/gpc_counter.sv
module gpc_counter
  import gpc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             cnt_pin,
  input  logic [NCH-1:0]             gate_pin,
  input  logic                       gen_start,
  input  logic                       cfg_we,
  input  logic [$clog2(NCH+1)-1:0]   cfg_sel,
  input  logic [CW-1:0]              cfg_data,
  output logic [NCH-1:0]             chan_out,
  output logic                       gen_gate_out,
  output logic [NCH*CW-1:0]          rd_count,
  output logic [NCH-1:0]             done,
  output logic [NCH-1:0]             ovf
);
  localparam int SELW = $clog2(NCH+1);

  logic [NCH-1:0]    cnt_sync, gate_sync;
  logic [NCH-1:0]    chan_start, chan_end;
  logic [NCH*CW-1:0] cnt_flat;
  logic [CW-1:0]     reload_q;
  logic              gen_gate;
  chan_cfg_t         cfg_q [NCH];

  gpc_sync #(.W(NCH)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cnt_pin), .sync_out(cnt_sync));
  gpc_sync #(.W(NCH)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .async_in(gate_pin), .sync_out(gate_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= '0;
    else if (cfg_we && cfg_sel == SELW'(NCH)) reload_q <= cfg_data;
  end

  gpc_gate_gen #(.CW(CW)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(gen_start), .reload(reload_q),
    .gate_q(gen_gate));

  assign gen_gate_out = gen_gate;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic gate_src;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '{gen_sel: 1'b0, mode: GM_LEVEL};
      else if (cfg_we && cfg_sel == SELW'(i))
        cfg_q[i] <= '{gen_sel: cfg_data[1], mode: gate_mode_e'(cfg_data[0])};
    end

    assign gate_src = cfg_q[i].gen_sel ? gen_gate : gate_sync[i];

    gpc_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .cnt_lvl(cnt_sync[i]), .gate_lvl(gate_src),
      .mode_edge(cfg_q[i].mode == GM_EDGE),
      .cnt_q(cnt_flat[i*CW +: CW]), .rd_q(rd_count[i*CW +: CW]),
      .done_q(done[i]), .ovf_q(ovf[i]), .open_o(chan_out[i]),
      .start_o(chan_start[i]), .end_o(chan_end[i]));
  end
endmodule

// File: rtl/gpc_counter_chk.sv
module gpc_counter_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_start,
  input logic              gen_gate,
  input logic [CW-1:0]     reload_q,
  input logic [NCH*CW-1:0] cnt_flat,
  input logic [NCH*CW-1:0] rd_count,
  input logic [NCH-1:0]    chan_start,
  input logic [NCH-1:0]    chan_end,
  input logic [NCH-1:0]    done,
  input logic [NCH-1:0]    ovf
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  AST_GEN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_start && !gen_gate && reload_q != '0) |=> gen_gate); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[i*CW +: CW] == CMAX && !chan_start[i]) |=> cnt_flat[i*CW +: CW] == CMAX); // R5
    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[i]) |-> $past(cnt_flat[i*CW +: CW]) == CMAX); // R5
    AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[i]) |-> $past(chan_end[i])); // R4
    AST_READOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_end[i] |=> $stable(rd_count[i*CW +: CW])); // R4
  end
endmodule

bind gpc_counter gpc_counter_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_start(gen_start), .gen_gate(gen_gate),
  .reload_q(reload_q), .cnt_flat(cnt_flat), .rd_count(rd_count),
  .chan_start(chan_start), .chan_end(chan_end), .done(done), .ovf(ovf));

// File: tb/gpc_counter_tb.sv
module gpc_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] cnt_pin = '0, gate_pin = '0, man = '0, tog_en = '0;
  logic gen_start = 1'b0, cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [NCH-1:0] chan_out, done, ovf, done_prev = '0;
  logic gen_gate_out;
  logic [NCH*CW-1:0] rd_count;

  int checks = 0, errors = 0;
  bit finished = 0;
  int exp_ch[$], exp_cnt[$], exp_ovf[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpc_counter #(.NCH(NCH), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .gen_start(gen_start), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .chan_out(chan_out), .gen_gate_out(gen_gate_out),
    .rd_count(rd_count), .done(done), .ovf(ovf));

  always @(negedge clk)
    for (int i = 0; i < NCH; i++)
      cnt_pin[i] <= tog_en[i] ? ~cnt_pin[i] : man[i];

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_item(int ch, int cnt, int of);
    exp_ch.push_back(ch); exp_cnt.push_back(cnt); exp_ovf.push_back(of);
  endtask

  // monitor: scoreboard pop on each rising done
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (rst_n && done[i] && !done_prev[i]) begin
        if (exp_ch.size() == 0) check("R4 unexpected done", i, -1);
        else begin
          check("R4 done channel", i, exp_ch.pop_front());
          check("R1/R2/R3/R9 readout", int'(rd_count[i*CW +: CW]), exp_cnt.pop_front());
          check("R5 overflow flag", int'(ovf[i]), exp_ovf.pop_front());
        end
      end
    end
    done_prev <= done;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int ch, int n);
    repeat (n) begin
      man[ch] = 1'b1; cyc(2);
      man[ch] = 1'b0; cyc(2);
    end
  endtask

  task automatic cfg(int sel, int data);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_data = CW'(data);
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R4 reset state
    check("R4 reset rd_count", int'(rd_count == '0), 1);
    check("R4 reset done", int'(done), 0);
    check("R4 reset ovf", int'(ovf), 0);
    check("R8 reset chan_out", int'(chan_out), 0);
    check("R6 reset gen gate", int'(gen_gate_out), 0);

    // R2/R1 level mode: pulses with gate low are ignored
    pulses(0, 3);
    expect_item(0, 4, 0);
    gate_pin[0] = 1'b1; cyc(4);
    check("R8 chan_out level open", int'(chan_out[0]), 1);
    pulses(0, 4); cyc(3);
    gate_pin[0] = 1'b0; cyc(6);
    check("R8 chan_out level closed", int'(chan_out[0]), 0);

    // R4: done clears on next open, readout held meanwhile
    expect_item(0, 2, 0);
    gate_pin[0] = 1'b1; cyc(5);
    check("R4 done cleared at open", int'(done[0]), 0);
    check("R4 readout held", int'(rd_count[CW-1:0]), 4);
    pulses(0, 2); cyc(3);
    gate_pin[0] = 1'b0; cyc(6);

    // R3 edge mode
    cfg(0, 1);
    expect_item(0, 5, 0);
    gate_pin[0] = 1'b1; cyc(2); gate_pin[0] = 1'b0; cyc(4);
    check("R8 chan_out edge open", int'(chan_out[0]), 1);
    pulses(0, 5); cyc(3);
    gate_pin[0] = 1'b1; cyc(2); gate_pin[0] = 1'b0; cyc(6);
    check("R8 chan_out edge closed", int'(chan_out[0]), 0);

    // R9 pulse width with known clock of period 2
    tog_en[3] = 1'b1;
    expect_item(3, 10, 0);
    gate_pin[3] = 1'b1; cyc(20); gate_pin[3] = 1'b0; cyc(6);

    // R6/R7 shared generated window, restart while busy ignored
    cfg(NCH, 40);
    cfg(1, 2); cfg(2, 2);
    tog_en[1] = 1'b1; tog_en[2] = 1'b1;
    expect_item(1, 20, 0); expect_item(2, 20, 0);
    gen_start = 1'b1; cyc(1); gen_start = 1'b0;
    w = 0;
    while (gen_gate_out && w < 100) begin
      w++;
      gen_start = (w == 10);
      cyc(1);
    end
    gen_start = 1'b0;
    check("R6 window length", w, 40);
    cyc(6);

    // R6 reload 0 ignored
    cfg(NCH, 0);
    gen_start = 1'b1; cyc(1); gen_start = 1'b0; cyc(3);
    check("R6 zero reload no window", int'(gen_gate_out), 0);
    check("R7 shared channel stays closed", int'(chan_out[1]), 0);
    tog_en[1] = 1'b0; tog_en[2] = 1'b0;

    // R5 saturation and sticky overflow
    expect_item(3, 65535, 1);
    gate_pin[3] = 1'b1; cyc(131100); gate_pin[3] = 1'b0; cyc(6);
    check("R5 ovf sticky after close", int'(ovf[3]), 1);
    expect_item(3, 2, 0);
    gate_pin[3] = 1'b1; cyc(3);
    check("R5 ovf cleared at open", int'(ovf[3]), 0);
    cyc(1); gate_pin[3] = 1'b0; cyc(6);
    tog_en[3] = 1'b0;

    check("R4 all expected intervals closed", exp_ch.size(), 0);
    finish_run();
  end
endmodule